// File: doc/BRIEF.md
# Exception Entry Controller

This block moves a processor from normal execution into an exception handler in one step. Each cycle it looks at three possible sources. The first is a synchronous exception strobe with its 5-bit code. The other two are the external and timer interrupt requests, each gated by its enable bit in the live status register. It picks at most one of them.

For an accepted exception whose code lies in the defined range, it computes everything the register file must take on:

- the return address, corrected for a delay slot and for a system call;
- the faulting address, for an illegal instruction only;
- the saved status and the rewritten supervisor-mode status;
- the cleared power-management enables;
- the handler vector.

All of these are presented together, registered, in the cycle after the request was sampled. In that same cycle the block raises one-cycle strobes that tell the surrounding core to flush its translation cache, clear the delay-slot flag and drop the atomic reservation.

A code of zero, or a code at or above the number of defined exceptions, is never vectored. Such a code raises a fatal-error strobe instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On commit, `epc_o` equals the sampled PC, minus 4 when `dslot_i` was high. Status bit 6 (delay-slot exception) of `sr_o` equals the sampled `dslot_i`, and `dslot_clr_o` equals the sampled `dslot_i`.
- R2: When the committed code equals CODE_SYSCALL (default 12), 4 is added to `epc_o` after the delay-slot correction.
- R3: `eear_we_o` is high only on a commit whose code equals CODE_ILLEGAL (default 7), and then `eear_o` equals the sampled PC.
- R4: On commit, `esr_o` equals the sampled `sr_i`. In `sr_o`, bit 0 (supervisor) is set. Bit 1 (interrupt enable), bit 2 (tick enable), bit 3 (data MMU enable) and bit 4 (instruction MMU enable) are cleared. Every other bit keeps its sampled value, except bit 6, which follows R1.
- R5: On commit, `pmr_o` equals the sampled `pmr_i` with bit 0 (doze enable) and bit 1 (sleep enable) cleared. `flush_o` and `lock_clr_o` are high exactly in commit cycles.
- R6: On commit, `pc_o` is (code << 8). It is OR'd with `vbase_i` when `vbase_cfg_i` was high, and OR'd with 0xF0000000 when status bit 5 (high vectors) of `sr_i` was high.
- R7: Without a synchronous exception, an external request is taken only when status bit 1 is set, with code CODE_EXT (default 8). A timer request is taken only when status bit 2 is set, with code CODE_TICK (default 5). When both are taken, the timer code wins.
- R8: When `exc_valid_i` is high, `exc_code_i` is the code used, whatever interrupt requests are pending.
- R9: A selected code of 0, or of NUM_EXC (default 14) and above, gives `fatal_o` high and `commit_o` low in the next cycle.
- R10: When nothing is taken, `commit_o`, `fatal_o`, `flush_o`, `lock_clr_o` and `eear_we_o` are all low in the next cycle.
- R11: All outputs are zero while and after synchronous reset until a request is taken.
- R12: The strobes are valid in the cycle after sampling and last one cycle, so back-to-back requests give back-to-back commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| exc_valid_i | input | 1 | Synchronous exception present |
| exc_code_i | input | 5 | Synchronous exception code |
| irq_req_i | input | 1 | External interrupt request |
| tick_req_i | input | 1 | Timer interrupt request |
| pc_i | input | 32 | Current PC |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| sr_i | input | 32 | Live status register |
| pmr_i | input | 32 | Power-management register |
| vbase_cfg_i | input | 1 | Configuration says a vector base register is present |
| vbase_i | input | 32 | Vector base register |
| commit_o | output | 1 | Exception entry committed this cycle |
| fatal_o | output | 1 | Selected code was out of range |
| flush_o | output | 1 | Translation cache flush pulse |
| lock_clr_o | output | 1 | Invalidate atomic reservation |
| dslot_clr_o | output | 1 | Clear the delay-slot flag |
| code_o | output | 5 | Committed exception code |
| epc_o | output | 32 | Saved return address |
| eear_we_o | output | 1 | Write enable for the effective-address register |
| eear_o | output | 32 | Faulting address |
| esr_o | output | 32 | Saved status register |
| sr_o | output | 32 | Rewritten status register |
| pmr_o | output | 32 | Rewritten power-management register |
| pc_o | output | 32 | Handler vector |

## Verification
The bench builds the block with its default parameters: 14 defined codes, system call 12, illegal 7, timer 5 and external 8. The 5-bit code field therefore reaches both the zero code and the whole out-of-range band from 14 to 31. That makes every fatal path reachable alongside the valid ones. Random status words with the high-vector, enable and delay-slot bits toggled independently cover each combination of the vector terms and the interrupt gating. Directed cases pin the delay-slot-plus-system-call return address and the timer-over-external tie.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned CODE_W    = 5;
    localparam int unsigned VEC_SHIFT = 8;
    localparam int unsigned PC_STEP   = 4;

    localparam logic [XLEN-1:0] HIVEC_BASE = 32'hF000_0000;

    // live status register bit positions
    localparam int unsigned SR_SUP     = 0;
    localparam int unsigned SR_IRQ_EN  = 1;
    localparam int unsigned SR_TICK_EN = 2;
    localparam int unsigned SR_DMMU_EN = 3;
    localparam int unsigned SR_IMMU_EN = 4;
    localparam int unsigned SR_HIVEC   = 5;
    localparam int unsigned SR_DSX     = 6;

    // power-management register bit positions
    localparam int unsigned PM_DOZE  = 0;
    localparam int unsigned PM_SLEEP = 1;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_SYNC,
        SRC_TICK,
        SRC_EXT
    } exc_src_e;

    typedef struct packed {
        exc_src_e          src;
        logic [CODE_W-1:0] code;
    } exc_sel_t;

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic            eear_we;
        logic [XLEN-1:0] eear;
        logic [XLEN-1:0] esr;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] pmr;
    } exc_state_t;

    function automatic logic code_in_range(input logic [CODE_W-1:0] c,
                                           input int unsigned n);
        return (c != '0) && (32'(c) < n);
    endfunction

    function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr,
                                                 input logic dslot);
        logic [XLEN-1:0] r;
        r = sr;
        r[SR_SUP]     = 1'b1;
        r[SR_IRQ_EN]  = 1'b0;
        r[SR_TICK_EN] = 1'b0;
        r[SR_DMMU_EN] = 1'b0;
        r[SR_IMMU_EN] = 1'b0;
        r[SR_DSX]     = dslot;
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_TICK = 5'd5,
    parameter logic [CODE_W-1:0] CODE_EXT  = 5'd8
) (
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              tick_req_i,
    input  logic              irq_en_i,
    input  logic              tick_en_i,
    output exc_sel_t          sel_o
);

    logic irq_take;
    logic tick_take;

    assign irq_take  = irq_req_i  & irq_en_i;
    assign tick_take = tick_req_i & tick_en_i;

    // synchronous first, then timer, then external
    always_comb begin
        sel_o.src  = SRC_NONE;
        sel_o.code = '0;
        if (exc_valid_i) begin
            sel_o.src  = SRC_SYNC;
            sel_o.code = exc_code_i;
        end else if (tick_take) begin
            sel_o.src  = SRC_TICK;
            sel_o.code = CODE_TICK;
        end else if (irq_take) begin
            sel_o.src  = SRC_EXT;
            sel_o.code = CODE_EXT;
        end
    end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_SYSCALL = 5'd12,
    parameter logic [CODE_W-1:0] CODE_ILLEGAL = 5'd7
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              dslot_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pmr_i,
    output exc_state_t        st_o
);

    logic [XLEN-1:0] pc_back;
    logic [XLEN-1:0] pc_fwd;

    // delay-slot correction first, system-call step after it
    assign pc_back = dslot_i ? XLEN'(PC_STEP) : '0;
    assign pc_fwd  = (code_i == CODE_SYSCALL) ? XLEN'(PC_STEP) : '0;

    always_comb begin
        st_o.epc     = pc_i - pc_back + pc_fwd;
        st_o.eear_we = (code_i == CODE_ILLEGAL);
        st_o.eear    = pc_i;
        st_o.esr     = sr_i;
        st_o.sr      = entry_sr(sr_i, dslot_i);
        st_o.pmr           = pmr_i;
        st_o.pmr[PM_DOZE]  = 1'b0;
        st_o.pmr[PM_SLEEP] = 1'b0;
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              vbase_cfg_i,
    input  logic [XLEN-1:0]   vbase_i,
    input  logic              hivec_i,
    output logic [XLEN-1:0]   vec_o
);

    localparam int unsigned PAD_W = XLEN - CODE_W - VEC_SHIFT;

    logic [XLEN-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, code_i, {VEC_SHIFT{1'b0}}};
    assign vec_o  = offset
                  | (vbase_cfg_i ? vbase_i    : '0)
                  | (hivec_i     ? HIVEC_BASE : '0);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned       NUM_EXC      = 14,
    parameter logic [CODE_W-1:0] CODE_SYSCALL = 5'd12,
    parameter logic [CODE_W-1:0] CODE_ILLEGAL = 5'd7,
    parameter logic [CODE_W-1:0] CODE_TICK    = 5'd5,
    parameter logic [CODE_W-1:0] CODE_EXT     = 5'd8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              tick_req_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              dslot_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pmr_i,
    input  logic              vbase_cfg_i,
    input  logic [XLEN-1:0]   vbase_i,
    output logic              commit_o,
    output logic              fatal_o,
    output logic              flush_o,
    output logic              lock_clr_o,
    output logic              dslot_clr_o,
    output logic [CODE_W-1:0] code_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              eear_we_o,
    output logic [XLEN-1:0]   eear_o,
    output logic [XLEN-1:0]   esr_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   pmr_o,
    output logic [XLEN-1:0]   pc_o
);

    exc_sel_t        sel;
    exc_state_t      st_next;
    logic [XLEN-1:0] vec_next;
    logic            accept;
    logic            in_range;
    logic            do_commit;

    exc_arbiter #(
        .CODE_TICK (CODE_TICK),
        .CODE_EXT  (CODE_EXT)
    ) u_arb (
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_req_i   (irq_req_i),
        .tick_req_i  (tick_req_i),
        .irq_en_i    (sr_i[SR_IRQ_EN]),
        .tick_en_i   (sr_i[SR_TICK_EN]),
        .sel_o       (sel)
    );

    exc_state_calc #(
        .CODE_SYSCALL (CODE_SYSCALL),
        .CODE_ILLEGAL (CODE_ILLEGAL)
    ) u_state (
        .code_i  (sel.code),
        .pc_i    (pc_i),
        .dslot_i (dslot_i),
        .sr_i    (sr_i),
        .pmr_i   (pmr_i),
        .st_o    (st_next)
    );

    exc_vector_gen u_vec (
        .code_i      (sel.code),
        .vbase_cfg_i (vbase_cfg_i),
        .vbase_i     (vbase_i),
        .hivec_i     (sr_i[SR_HIVEC]),
        .vec_o       (vec_next)
    );

    assign accept    = (sel.src != SRC_NONE);
    assign in_range  = code_in_range(sel.code, NUM_EXC);
    assign do_commit = accept & in_range;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            commit_o    <= 1'b0;
            fatal_o     <= 1'b0;
            flush_o     <= 1'b0;
            lock_clr_o  <= 1'b0;
            dslot_clr_o <= 1'b0;
            eear_we_o   <= 1'b0;
            code_o      <= '0;
            epc_o       <= '0;
            eear_o      <= '0;
            esr_o       <= '0;
            sr_o        <= '0;
            pmr_o       <= '0;
            pc_o        <= '0;
        end else begin
            commit_o    <= do_commit;
            fatal_o     <= accept & ~in_range;
            flush_o     <= do_commit;
            lock_clr_o  <= do_commit;
            dslot_clr_o <= do_commit & dslot_i;
            eear_we_o   <= do_commit & st_next.eear_we;
            if (do_commit) begin
                code_o <= sel.code;
                epc_o  <= st_next.epc;
                esr_o  <= st_next.esr;
                sr_o   <= st_next.sr;
                pmr_o  <= st_next.pmr;
                pc_o   <= vec_next;
            end
            if (do_commit && st_next.eear_we) begin
                eear_o <= st_next.eear;
            end
        end
    end

    a_r9_zero_code_fatal: assert property (@(posedge clk_i) disable iff (rst_i)
        (exc_valid_i && exc_code_i == '0) |=> (fatal_o && !commit_o));

    a_r4_status_saved: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> (esr_o == $past(sr_i)));

    a_r4_supervisor_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> (sr_o[SR_SUP] && !sr_o[SR_IRQ_EN] && !sr_o[SR_TICK_EN]
                      && !sr_o[SR_DMMU_EN] && !sr_o[SR_IMMU_EN]));

    a_r7_tick_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (!exc_valid_i && tick_req_i && sr_i[SR_TICK_EN]) |=> (code_o == CODE_TICK));

    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (!exc_valid_i && !(tick_req_i && sr_i[SR_TICK_EN]) && !(irq_req_i && sr_i[SR_IRQ_EN]))
        |=> (!commit_o && !fatal_o && !flush_o && !eear_we_o));

    a_r5_flush_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> (flush_o && lock_clr_o && !pmr_o[PM_DOZE] && !pmr_o[PM_SLEEP]));

    a_r8_sync_code_used: assert property (@(posedge clk_i) disable iff (rst_i)
        (exc_valid_i && code_in_range(exc_code_i, NUM_EXC)) |=> (commit_o && code_o == $past(exc_code_i)));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

    localparam int unsigned NUM_EXC = 14;
    localparam int unsigned C_SYS   = 12;
    localparam int unsigned C_ILL   = 7;
    localparam int unsigned C_TICK  = 5;
    localparam int unsigned C_EXT   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        irq_req = 1'b0;
    logic        tick_req = 1'b0;
    logic [31:0] pc = '0;
    logic        dslot = 1'b0;
    logic [31:0] sr = '0;
    logic [31:0] pmr = '0;
    logic        vcfg = 1'b0;
    logic [31:0] vbase = '0;

    logic        commit, fatal, flush, lock_clr, dslot_clr, eear_we;
    logic [4:0]  code;
    logic [31:0] epc, eear, esr, sr_n, pmr_n, pc_n;

    int checks = 0;
    int errors = 0;

    // expectation for the cycle after the last drive
    bit          e_have = 0;
    bit          e_commit, e_fatal, e_dsc, e_we;
    int unsigned e_code;
    logic [31:0] e_epc, e_eear, e_esr, e_sr, e_pmr, e_pc;

    always #5 clk = ~clk;

    exc_entry_ctrl #(
        .NUM_EXC      (NUM_EXC),
        .CODE_SYSCALL (5'(C_SYS)),
        .CODE_ILLEGAL (5'(C_ILL)),
        .CODE_TICK    (5'(C_TICK)),
        .CODE_EXT     (5'(C_EXT))
    ) u_dut (
        .clk_i (clk), .rst_i (rst),
        .exc_valid_i (exc_valid), .exc_code_i (exc_code),
        .irq_req_i (irq_req), .tick_req_i (tick_req),
        .pc_i (pc), .dslot_i (dslot), .sr_i (sr), .pmr_i (pmr),
        .vbase_cfg_i (vcfg), .vbase_i (vbase),
        .commit_o (commit), .fatal_o (fatal), .flush_o (flush),
        .lock_clr_o (lock_clr), .dslot_clr_o (dslot_clr), .code_o (code),
        .epc_o (epc), .eear_we_o (eear_we), .eear_o (eear), .esr_o (esr),
        .sr_o (sr_n), .pmr_o (pmr_n), .pc_o (pc_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural reference for the inputs currently driven
    task automatic predict();
        int sel;
        sel = -1;
        if (exc_valid)                  sel = int'(exc_code);
        else if (tick_req && sr[2])     sel = C_TICK;
        else if (irq_req && sr[1])      sel = C_EXT;
        e_commit = (sel > 0) && (sel < NUM_EXC);
        e_fatal  = (sel == 0) || (sel >= int'(NUM_EXC));
        e_code   = (sel < 0) ? 0 : sel;
        e_dsc    = e_commit && dslot;
        e_we     = e_commit && (sel == C_ILL);
        e_epc    = pc;
        if (dslot)        e_epc = e_epc - 32'd4;
        if (sel == C_SYS) e_epc = e_epc + 32'd4;
        e_eear = pc;
        e_esr  = sr;
        e_sr   = (sr | 32'h1) & ~32'h1E;
        e_sr   = dslot ? (e_sr | 32'h40) : (e_sr & ~32'h40);
        e_pmr  = pmr & ~32'h3;
        e_pc   = 32'(e_code) * 256;
        if (vcfg)  e_pc = e_pc | vbase;
        if (sr[5]) e_pc = e_pc | 32'hF000_0000;
        e_have = 1;
    endtask

    task automatic compare();
        if (!e_have) return;
        chk("R9 R10 R7 R8", "commit", 32'(commit), 32'(e_commit));
        chk("R9", "fatal", 32'(fatal), 32'(e_fatal));
        chk("R5 R12", "flush", 32'(flush), 32'(e_commit));
        chk("R5", "lock_clr", 32'(lock_clr), 32'(e_commit));
        chk("R3", "eear_we", 32'(eear_we), 32'(e_we));
        chk("R1", "dslot_clr", 32'(dslot_clr), 32'(e_dsc));
        if (e_commit) begin
            chk("R7 R8", "code", 32'(code), e_code);
            chk("R1 R2", "epc", epc, e_epc);
            chk("R4", "esr", esr, e_esr);
            chk("R4 R1", "sr", sr_n, e_sr);
            chk("R5", "pmr", pmr_n, e_pmr);
            chk("R6", "vector", pc_n, e_pc);
            if (e_we) chk("R3", "eear", eear, e_eear);
        end
    endtask

    // at a falling edge: check last cycle, then drive the next request
    task automatic step(input bit ev, input int unsigned c, input bit irq,
                        input bit tick, input logic [31:0] p, input bit ds,
                        input logic [31:0] s, input logic [31:0] pm,
                        input bit vc, input logic [31:0] vb);
        @(negedge clk);
        compare();
        exc_valid = ev; exc_code = 5'(c); irq_req = irq; tick_req = tick;
        pc = p; dslot = ds; sr = s; pmr = pm; vcfg = vc; vbase = vb;
        predict();
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "commit", 32'(commit), 32'd0);
        chk("R11", "fatal", 32'(fatal), 32'd0);
        chk("R11", "sr", sr_n, 32'd0);
        chk("R11", "vector", pc_n, 32'd0);
        rst = 1'b0;
        predict();

        // R2 syscall, no delay slot
        step(1, C_SYS, 0, 0, 32'h0000_1000, 0, 32'h0000_0006, 32'hFF, 0, 0);
        // R1 R2 syscall in delay slot: net zero
        step(1, C_SYS, 0, 0, 32'h0000_2000, 1, 32'h0000_001F, 32'h3, 1, 32'h0001_0000);
        // R3 illegal, back to back
        step(1, C_ILL, 0, 0, 32'hDEAD_BEE0, 0, 32'hFFFF_FFFF, 32'h0, 0, 0);
        // R9 code zero, code at limit, code max
        step(1, 0, 1, 1, 32'h10, 0, 32'h6, 0, 0, 0);
        step(1, NUM_EXC, 0, 0, 32'h20, 0, 32'h0, 0, 0, 0);
        step(1, 31, 0, 0, 32'h30, 0, 32'h0, 0, 0, 0);
        // R7 external enabled, external disabled
        step(0, 0, 1, 0, 32'h400, 0, 32'h2, 32'h7, 0, 0);
        step(0, 0, 1, 0, 32'h404, 0, 32'h0, 0, 0, 0);
        // R7 both enabled: timer wins; timer disabled falls to external
        step(0, 0, 1, 1, 32'h408, 0, 32'h6, 0, 0, 0);
        step(0, 0, 1, 1, 32'h40C, 0, 32'h2, 0, 0, 0);
        // R8 sync beats timer
        step(1, 3, 1, 1, 32'h500, 1, 32'h6, 0, 0, 0);
        // R6 base and high region together
        step(1, 9, 0, 0, 32'h600, 0, 32'h20, 0, 1, 32'h0012_3400);
        // R10 idle with requests masked
        step(0, 0, 1, 1, 32'h700, 0, 32'h0, 0, 1, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 32'h0, 0, 32'h0, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int unsigned cc;
            cc = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? C_SYS : C_ILL)
                                             : $urandom_range(0, 31);
            step(bit'($urandom_range(0, 1)), cc, bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), $urandom, bit'($urandom_range(0, 1)),
                 $urandom, $urandom, bit'($urandom_range(0, 1)), $urandom);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule